// File: doc/BRIEF.md
# GPIO controller with grouped interrupts

This block manages 32 general-purpose pins behind a small word-addressed register bus. Software sets each pin's direction and its driven level. It can also make an output pin blink from a shared square wave. Every input bit can be inverted before the block uses it. Input pins pass through a two-stage synchroniser. The result, XORed with the polarity register, forms the data-in value. Software reads that value, and the level and edge interrupt logic are both built on it.

A 0-to-1 transition of an adjusted input bit sets a sticky edge-cause bit. Writing a zero to that bit clears it; writing a one leaves it alone. Level sources and edge sources each have their own enable mask. Each group of eight neighbouring pins is ORed into one summary interrupt line for a downstream interrupt controller. The blink timer is a two-state machine: PH_LOW moves to PH_HIGH, and PH_HIGH moves back to PH_LOW, each time the prescaler counter reaches BLINK_HALF-1.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction register holds all ones (every pin an input, `pin_oe` all zero), every other register holds zero, and `grp_irq` is zero.
- R2: A direction bit of 1 makes the pin an input and a 0 makes it an output: `pin_oe[i]` equals the inverse of direction bit i from the cycle after the write. A non-blinking output pin drives its output-register bit.
- R3: Data-in (offset 0x10) reads the synchronised pin level XORed with the polarity register (offset 0x0C). Writes to offset 0x10 have no effect.
- R4: A 0-to-1 change of a polarity-adjusted input bit sets its edge-cause bit (offset 0x14). The bit stays set after the input returns. With polarity 1, a falling pin sets the bit.
- R5: A write to the edge-cause register clears each bit written as 0 and keeps each bit written as 1. An edge that is latched in the same cycle as a clearing write stays set.
- R6: `grp_irq[g]` is the OR over pins 8g..8g+7 of (data-in AND level mask at 0x1C) OR (edge cause AND edge mask at 0x18).
- R7: An output pin whose blink-enable bit (0x08) is set follows a shared square wave that holds each level for BLINK_HALF cycles. All blinking pins are in phase. Clearing the bit returns the pin to its output-register bit.
- R8: A polarity write on its own, with no change at the pin, never sets an edge-cause bit.
- R9: Registers sit at word offsets 0x00 output, 0x04 direction, 0x08 blink enable, 0x0C polarity, 0x10 data-in, 0x14 edge cause, 0x18 edge mask and 0x1C level mask. A read returns data on `bus_rdata` one cycle after `bus_rd`. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read request; data is returned the next cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Level driven on each pin |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| grp_irq | output | 4 | One summary interrupt per group of eight pins |

## Verification
Some properties are checked on every cycle. A direction write shows up on `pin_oe` one cycle later. A rise of the adjusted input is always latched. Cause bits never drop without a write to the cause register. A pin that stays level never creates a cause bit, whatever the polarity does. The summary lines stay low while both masks are zero. The blink wave never holds a level longer than BLINK_HALF cycles. Other behaviour needs the bench's scenarios: data-in values for full pin and polarity patterns, per-pin acknowledge by an inverted one-hot write, a clearing write that lands in the same cycle as an edge, the mapping of each pin to its group line, and the exact blink period and phase sharing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_OUT   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_BLINK = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_POL   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_DIN   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_EMASK = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_LMASK = 6'h1C;

    typedef enum logic [0:0] {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } blink_phase_e;
endpackage

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen
    import gpio_pkg::*;
#(
    parameter int BLINK_HALF = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic blink_lvl
);
    localparam int CW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;
    blink_phase_e  ph_q, ph_d;

    assign wrap = (cnt_q == CW'(BLINK_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ph_q  <= PH_LOW;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            ph_q  <= ph_d;
        end
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_LOW:  if (wrap) ph_d = PH_HIGH;
            PH_HIGH: if (wrap) ph_d = PH_LOW;
            default: ph_d = PH_LOW;
        endcase
    end

    always_comb blink_lvl = (ph_q == PH_HIGH);
endmodule

// File: rtl/gpio_in_stage.sv
module gpio_in_stage #(
    parameter int N    = 32,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_raw,
    input  logic [N-1:0] pol,
    output logic [N-1:0] din,
    output logic [N-1:0] edge_evt
);
    // stage SYNC-1 is the synchronised level, stage SYNC its previous value
    logic [SYNC:0][N-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[SYNC-1:0], pin_raw};
    end

    // both terms use today's polarity, so a polarity write alone is no edge
    assign din      = stg_q[SYNC-1] ^ pol;
    assign edge_evt = din & ~(stg_q[SYNC] ^ pol);
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int N = 32,
    parameter int G = 8
) (
    input  logic [N-1:0]   lvl_src,
    input  logic [N-1:0]   edge_src,
    output logic [N/G-1:0] grp
);
    localparam int NG = N / G;

    logic [N-1:0] any_src;
    assign any_src = lvl_src | edge_src;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp[g] = |any_src[g*G +: G];
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int GRP        = 8,
    parameter int SYNC       = 2,
    parameter int BLINK_HALF = 500000,
    localparam int NGRP      = NPINS / GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NGRP-1:0]   grp_irq
);
    logic [NPINS-1:0] out_q, dir_q, blink_q, pol_q;
    logic [NPINS-1:0] cause_q, cause_d, emask_q, lmask_q;
    logic [NPINS-1:0] din_w, edge_evt;
    logic             blink_lvl;
    logic             wr_cause;

    gpio_in_stage #(.N(NPINS), .SYNC(SYNC)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pol      (pol_q),
        .din      (din_w),
        .edge_evt (edge_evt)
    );

    gpio_blink_gen #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk       (clk),
        .rst_n     (rst_n),
        .blink_lvl (blink_lvl)
    );

    gpio_irq_group #(.N(NPINS), .G(GRP)) u_grp (
        .lvl_src  (din_w & lmask_q),
        .edge_src (cause_q & emask_q),
        .grp      (grp_irq)
    );

    assign wr_cause = bus_wr && (bus_addr == OFS_CAUSE);

    // write-zero clears; a new event in the same cycle wins
    always_comb begin
        cause_d = wr_cause ? (cause_q & bus_wdata) : cause_q;
        cause_d = cause_d | edge_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
            cause_q <= '0;
        end else begin
            cause_q <= cause_d;
            if (bus_wr) begin
                case (bus_addr)
                    OFS_OUT:   out_q   <= bus_wdata;
                    OFS_DIR:   dir_q   <= bus_wdata;
                    OFS_BLINK: blink_q <= bus_wdata;
                    OFS_POL:   pol_q   <= bus_wdata;
                    OFS_EMASK: emask_q <= bus_wdata;
                    OFS_LMASK: lmask_q <= bus_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_OUT:   bus_rdata <= out_q;
                OFS_DIR:   bus_rdata <= dir_q;
                OFS_BLINK: bus_rdata <= blink_q;
                OFS_POL:   bus_rdata <= pol_q;
                OFS_DIN:   bus_rdata <= din_w;
                OFS_CAUSE: bus_rdata <= cause_q;
                OFS_EMASK: bus_rdata <= emask_q;
                OFS_LMASK: bus_rdata <= lmask_q;
                default:   bus_rdata <= '0;
            endcase
        end
    end

    assign pin_oe  = ~dir_q;
    assign pin_out = (blink_q & {NPINS{blink_lvl}}) | (~blink_q & out_q);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int NGRP       = 4,
    parameter int BLINK_HALF = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NGRP-1:0]   grp_irq,
    input logic [NPINS-1:0]  din,
    input logic [NPINS-1:0]  pol,
    input logic [NPINS-1:0]  cause,
    input logic [NPINS-1:0]  lmask,
    input logic [NPINS-1:0]  emask,
    input logic              blink_lvl
);
    logic [NPINS-1:0] din_q, pol_q, raw_q, raw, rise;
    logic             lvl_q;
    int unsigned      run;

    assign raw  = din ^ pol;
    assign rise = din & ~din_q & ~(pol ^ pol_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q <= '0;
            pol_q <= '0;
            raw_q <= '0;
            lvl_q <= 1'b0;
            run   <= 0;
        end else begin
            din_q <= din;
            pol_q <= pol;
            raw_q <= raw;
            lvl_q <= blink_lvl;
            run   <= (blink_lvl != lvl_q) ? 1 : run + 1;
        end
    end

    p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR) |=> (pin_oe == ~$past(bus_wdata)));

    p_edge_latches_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((cause & $past(rise)) == $past(rise)));

    p_cause_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_CAUSE) |=> ((~cause & $past(cause)) == '0));

    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lmask == '0 && emask == '0) |-> (grp_irq == '0));

    p_blink_dwell_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run <= BLINK_HALF);

    p_pol_no_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause & ~$past(cause) & ~$past(raw ^ raw_q)) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
    .NPINS      (NPINS),
    .NGRP       (NGRP),
    .BLINK_HALF (BLINK_HALF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .grp_irq   (grp_irq),
    .din       (din_w),
    .pol       (pol_q),
    .cause     (cause_q),
    .lmask     (lmask_q),
    .emask     (emask_q),
    .blink_lvl (blink_lvl)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    localparam int HALF = 4;
    localparam logic [5:0] A_OUT = 6'h00, A_DIR = 6'h04, A_BLK = 6'h08, A_POL = 6'h0C;
    localparam logic [5:0] A_DIN = 6'h10, A_CAU = 6'h14, A_EMK = 6'h18, A_LMK = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
    logic [3:0]  grp_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.BLINK_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .grp_irq(grp_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [3:0] grp_model(input logic [31:0] dn, lm, ca, em);
        logic [31:0] s = (dn & lm) | (ca & em);
        for (int g = 0; g < 4; g++) grp_model[g] = |s[g*8 +: 8];
    endfunction

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL all watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d, p, q;
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state, R9 read map
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 grp_irq", {28'h0, grp_irq}, 32'h0);
        rd(A_DIR, d); chk("R1 dir", d, 32'hFFFF_FFFF);
        rd(A_OUT, d); chk("R1 out", d, 32'h0);
        rd(A_BLK, d); chk("R1 blink", d, 32'h0);
        rd(A_POL, d); chk("R1 pol", d, 32'h0);
        rd(A_CAU, d); chk("R1 cause", d, 32'h0);
        rd(A_EMK, d); chk("R1 emask", d, 32'h0);
        rd(A_LMK, d); chk("R1 lmask", d, 32'h0);

        // R2 direction and output data, R9 readback
        wr(A_OUT, 32'hA5A5_0F0F);
        wr(A_DIR, 32'h0000_FFFF);
        chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        chk("R2 pin_out", pin_out & 32'hFFFF_0000, 32'hA5A5_0000);
        rd(A_OUT, d); chk("R9 out readback", d, 32'hA5A5_0F0F);
        rd(A_DIR, d); chk("R9 dir readback", d, 32'h0000_FFFF);
        rd(6'h20, d); chk("R9 unmapped", d, 32'h0);
        wr(A_DIR, 32'hFFFF_FFFF);
        chk("R2 all inputs", pin_oe, 32'h0);

        // R3 data-in sweep
        for (int k = 0; k < 8; k++) begin
            p = 32'h9E37_79B9 * (k + 1);
            q = (32'h0F0F_3C3C << k) ^ (32'h1 << (k * 3));
            wr(A_POL, q);
            pin_in = p;
            settle(3);
            rd(A_DIN, d); chk("R3 din", d, p ^ q);
            wr(A_DIN, ~(p ^ q));
            rd(A_DIN, d); chk("R3 din write ignored", d, p ^ q);
        end
        wr(A_POL, 32'h0);
        pin_in = 32'h0;
        settle(4);
        wr(A_CAU, 32'h0);

        // R4 / R5 per pin: latch, hold, write-one no effect, one-hot ack
        for (int i = 0; i < 32; i++) begin
            pin_in = 32'h1 << i;
            settle(4);
            rd(A_CAU, d); chk("R4 latch", d, 32'h1 << i);
            pin_in = 32'h0;
            settle(4);
            rd(A_CAU, d); chk("R4 sticky", d, 32'h1 << i);
            wr(A_CAU, 32'hFFFF_FFFF);
            rd(A_CAU, d); chk("R5 write ones keeps", d, 32'h1 << i);
            wr(A_CAU, ~(32'h1 << i));
            rd(A_CAU, d); chk("R5 one-hot ack", d, 32'h0);
        end

        // R5 clearing write in the same cycle as a new edge
        pin_in = 32'h0000_0100;
        settle(4);
        pin_in = 32'h0000_0101;
        @(negedge clk);
        wr(A_CAU, 32'h0);
        rd(A_CAU, d); chk("R5 set wins over clear", d, 32'h0000_0001);
        pin_in = 32'h0;
        settle(4);
        wr(A_CAU, 32'h0);

        // R8 polarity flips alone, then R4 falling edge via polarity
        pin_in = 32'hFFFF_FFFF;
        settle(4);
        wr(A_CAU, 32'h0);
        wr(A_POL, 32'hFFFF_FFFF);
        settle(3);
        wr(A_POL, 32'h0);
        settle(3);
        rd(A_CAU, d); chk("R8 no edge from polarity", d, 32'h0);
        wr(A_POL, 32'hFFFF_FFFF);
        settle(3);
        wr(A_CAU, 32'h0);
        pin_in = 32'h0;
        settle(4);
        rd(A_CAU, d); chk("R4 falling with pol 1", d, 32'hFFFF_FFFF);
        wr(A_POL, 32'h0);
        settle(3);
        wr(A_CAU, 32'h0);

        // R6 level sources, each pin to its group line
        wr(A_LMK, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            pin_in = 32'h1 << i;
            settle(3);
            chk("R6 level group", {28'h0, grp_irq}, {28'h0, grp_model(pin_in, 32'hFFFF_FFFF, 32'h0, 32'h0)});
            wr(A_LMK, ~(32'h1 << i));
            chk("R6 level masked", {28'h0, grp_irq}, 32'h0);
            wr(A_LMK, 32'hFFFF_FFFF);
        end
        wr(A_LMK, 32'h0);
        pin_in = 32'h0;
        settle(4);
        wr(A_CAU, 32'h0);

        // R6 edge sources
        for (int g = 0; g < 4; g++) begin
            p = 32'h1 << (g * 8 + 3);
            pin_in = p;
            settle(4);
            pin_in = 32'h0;
            settle(1);
            chk("R6 edge masked", {28'h0, grp_irq}, 32'h0);
            wr(A_EMK, p);
            chk("R6 edge group", {28'h0, grp_irq}, {28'h0, grp_model(32'h0, 32'h0, p, p)});
            wr(A_CAU, ~p);
            chk("R6 edge acked", {28'h0, grp_irq}, 32'h0);
            wr(A_EMK, 32'h0);
        end

        // R7 blink: pins 0 and 5 blink, pin 1 holds its output bit
        wr(A_OUT, 32'h0000_0002);
        wr(A_DIR, 32'h0);
        wr(A_BLK, 32'h0000_0021);
        begin
            logic prev;
            int   run;
            int   seen;
            prev = pin_out[0];
            run  = 0;
            seen = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                run++;
                if (pin_out[0] != prev) begin
                    if (seen > 0) chk("R7 half period", run, HALF);
                    seen++;
                    run  = 0;
                    prev = pin_out[0];
                end
                if (c % 8 == 0) begin
                    chk("R7 shared phase", {31'h0, pin_out[5]}, {31'h0, pin_out[0]});
                    chk("R2 steady output", {31'h0, pin_out[1]}, 32'h1);
                end
            end
            chk("R7 toggles seen", (seen >= 8) ? 32'h1 : 32'h0, 32'h1);
        end
        wr(A_BLK, 32'h0);
        settle(HALF);
        chk("R7 blink off", pin_out & 32'h0000_0023, 32'h0000_0002);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule